// File: doc/BRIEF.md
# Gated Audio Control Register Bank

This block holds the 16-bit control registers that steer a four-channel sound generator, plus a small waveform sample memory. A processor reaches it through a simple bus. The bus has a halfword address, write data, a write strobe, two byte-lane enables, a read strobe and registered read data. Each stored register keeps only the bits that the sound hardware defines. Undefined bits are cleared when the register is written, so they read back as zero.

A master enable bit in the master control register guards the whole block of channel registers. While the bit is clear, writes to that block are dropped and reads of the channel registers return zero. The master register, the mixing-to-DMA register, the bias register and the waveform memory stay reachable at all times. The waveform memory holds four 32-bit words, and each word is reached as two halfwords. A partial write merges with the stored contents of the word. All stored fields are driven straight out to the sound channels.

Top module: `audbank_top`

## Requirements
- R1: While `rst_ni` is low at a clock edge, the following outputs are zero after that edge: every channel register, `master_en_o`, the waveform memory and `rd_data_o`. `bias_o` is 0x0200.
- R2: Each channel register stores the merged write data ANDed with its own keep-mask. Registers without a listed mask keep all 16 bits. The registers, by halfword address, with their slot in `chan_regs_o` (slot k is bits [16k+15:16k]) and keep-mask:

  | Address | Register | Slot | Keep-mask |
  |---|---|---|---|
  | 0x00 | channel 1 sweep | 0 | 0x007F |
  | 0x01 | channel 1 duty/envelope | 1 | all 16 bits |
  | 0x02 | channel 1 frequency/control | 2 | 0x47FF |
  | 0x04 | channel 2 duty/envelope | 3 | all 16 bits |
  | 0x06 | channel 2 frequency/control | 4 | 0x47FF |
  | 0x08 | channel 3 enable | 5 | 0x00E0 |
  | 0x09 | channel 3 length/volume | 6 | 0xE03F |
  | 0x0A | channel 3 frequency/control | 7 | 0x47FF |
  | 0x0C | channel 4 envelope | 8 | 0xFF3F |
  | 0x0E | channel 4 control | 9 | 0x40FF |
  | 0x10 | left/right mixing | 10 | 0xFF77 |
  | 0x11 | mixing-to-DMA | 11 | 0x770F |

- R3: A write replaces only the byte lanes whose enable is set. `be_i[0]` selects bits 7:0 and `be_i[1]` selects bits 15:8. The other lane keeps its stored value. The R2 keep-mask is applied after the merge.
- R4: Address 0x12 is the master register. It reads as bit 7 = `master_en_o`, bits 3:0 = `chan_active_i` and all other bits 0. A write with `be_i[0]` set loads bit 7 of the write data into the enable. No write changes bits 3:0.
- R5: While `master_en_o` is 0, writes to addresses 0x00 through 0x10 inclusive change no stored state.
- R6: While `master_en_o` is 0, reads of addresses 0x00 through 0x10 return 0. Stored values are kept. Address 0x11, the master register and the bias register at 0x14 (written as in R2 with all bits kept) stay readable and writable.
- R7: Addresses 0x18 to 0x1F reach the waveform memory. Word k sits at 0x18+2k (bits 15:0) and 0x19+2k (bits 31:16) and is output on `wave_o` bits [32k+31:32k]. A halfword write leaves the other half of the word unchanged.
- R8: The waveform memory is written and read normally whatever the value of `master_en_o`.
- R9: Unmapped addresses (0x03, 0x05, 0x07, 0x0B, 0x0D, 0x0F, 0x13, 0x15 to 0x17, 0x20 to 0x3F) read as 0 and writes to them change nothing.
- R10: `rd_data_o` takes the addressed value on the clock edge that samples `rd_en_i` high and holds it while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| hw_addr_i | input | 6 | Halfword address within the bank |
| wr_en_i | input | 1 | Write strobe |
| be_i | input | 2 | Byte-lane enables for writes |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Registered read data |
| chan_active_i | input | 4 | Per-channel active status from the channels |
| chan_regs_o | output | 192 | Twelve stored channel registers, slot k at [16k+15:16k] |
| master_en_o | output | 1 | Master sound enable |
| bias_o | output | 16 | Bias register |
| wave_o | output | 128 | Waveform memory, word k at [32k+31:32k] |

## Verification
Every masked register is written with all ones, so the stored value equals its keep-mask and a wrong mask or slot shows at once. Single-lane writes over values that are not zero test the merge, including a high-lane write where a mask bit is cleared. The same channel addresses are then written and read with the enable both set and clear. This separates dropped writes and zeroed reads from lost state, and confirms that the DMA-mixing, bias, master and waveform addresses escape the gate. Unmapped holes inside and beyond the map are written with ones. The bench checks that no output moves.

// File: rtl/audbank_pkg.sv
// Package: shared constants, slot decode and keep-masks for the audio bank.
// Assumes a 6-bit halfword address space; the map is fixed by decode_slot.
package audbank_pkg;

    localparam int HW_ADDR_W   = 6;
    localparam int REG_W       = 16;
    localparam int NUM_CTL     = 12;
    localparam int CTL_IDX_W   = 4;
    localparam int WAVE_WORDS  = 4;
    localparam int WAVE_IDX_W  = $clog2(WAVE_WORDS);
    localparam int WORD_W      = 2 * REG_W;
    localparam int STATUS_W    = 4;
    localparam int EN_BIT      = 7;
    localparam logic [REG_W-1:0] BIAS_RST = 16'h0200;
    localparam logic [HW_ADDR_W-1:0] GATE_LAST = 6'h10;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_CTL,
        KIND_MASTER,
        KIND_BIAS,
        KIND_WAVE
    } kind_e;

    typedef struct packed {
        kind_e                 kind;
        logic [CTL_IDX_W-1:0]  ctl_idx;
        logic                  gated;
        logic [WAVE_IDX_W-1:0] word;
        logic                  half;
    } slot_t;

    // Map a halfword address onto its storage kind and index.
    function automatic slot_t decode_slot(input logic [HW_ADDR_W-1:0] a);
        slot_t s;
        s = '0;
        s.kind = KIND_NONE;
        s.gated = (a <= GATE_LAST);
        case (a)
            6'h00: begin s.kind = KIND_CTL; s.ctl_idx = 4'd0;  end
            6'h01: begin s.kind = KIND_CTL; s.ctl_idx = 4'd1;  end
            6'h02: begin s.kind = KIND_CTL; s.ctl_idx = 4'd2;  end
            6'h04: begin s.kind = KIND_CTL; s.ctl_idx = 4'd3;  end
            6'h06: begin s.kind = KIND_CTL; s.ctl_idx = 4'd4;  end
            6'h08: begin s.kind = KIND_CTL; s.ctl_idx = 4'd5;  end
            6'h09: begin s.kind = KIND_CTL; s.ctl_idx = 4'd6;  end
            6'h0A: begin s.kind = KIND_CTL; s.ctl_idx = 4'd7;  end
            6'h0C: begin s.kind = KIND_CTL; s.ctl_idx = 4'd8;  end
            6'h0E: begin s.kind = KIND_CTL; s.ctl_idx = 4'd9;  end
            6'h10: begin s.kind = KIND_CTL; s.ctl_idx = 4'd10; end
            6'h11: begin s.kind = KIND_CTL; s.ctl_idx = 4'd11; end
            6'h12: s.kind = KIND_MASTER;
            6'h14: s.kind = KIND_BIAS;
            default: begin
                if (a[5:3] == 3'b011) begin
                    s.kind = KIND_WAVE;
                    s.word = a[2:1];
                    s.half = a[0];
                end
            end
        endcase
        return s;
    endfunction

    // Bits each channel register keeps after a write.
    function automatic logic [REG_W-1:0] ctl_mask(input int idx);
        case (idx)
            0:       return 16'h007F;
            2, 4, 7: return 16'h47FF;
            5:       return 16'h00E0;
            6:       return 16'hE03F;
            8:       return 16'hFF3F;
            9:       return 16'h40FF;
            10:      return 16'hFF77;
            11:      return 16'h770F;
            default: return 16'hFFFF;
        endcase
    endfunction

endpackage

// File: rtl/audbank_decode.sv
// Module: audbank_decode
// Turns the bus address and strobes into per-target write enables and the
// byte-lane mask; applies the master-enable gate to the protected range.
// Assumes at most one access target per cycle (single address port).
module audbank_decode
    import audbank_pkg::*;
(
    input  logic [HW_ADDR_W-1:0] hw_addr_i,
    input  logic                 wr_en_i,
    input  logic [1:0]           be_i,
    input  logic                 master_en_i,
    output slot_t                slot_o,
    output logic                 blocked_o,
    output logic [REG_W-1:0]     lane_mask_o,
    output logic [NUM_CTL-1:0]   ctl_we_o,
    output logic                 master_we_o,
    output logic                 bias_we_o,
    output logic                 wave_we_o
);

    logic wr_ok;

    // Decode the address and compute the gated write enables.
    always_comb begin
        slot_o      = decode_slot(hw_addr_i);
        blocked_o   = slot_o.gated && !master_en_i;
        wr_ok       = wr_en_i && !blocked_o;
        lane_mask_o = {{8{be_i[1]}}, {8{be_i[0]}}};
        ctl_we_o    = '0;
        if (wr_ok && slot_o.kind == KIND_CTL) begin
            ctl_we_o[slot_o.ctl_idx] = 1'b1;
        end
        master_we_o = wr_ok && (slot_o.kind == KIND_MASTER) && be_i[0];
        bias_we_o   = wr_ok && (slot_o.kind == KIND_BIAS);
        wave_we_o   = wr_ok && (slot_o.kind == KIND_WAVE);
    end

endmodule

// File: rtl/audbank_ctl_regs.sv
// Module: audbank_ctl_regs
// Array of channel control registers; each merges byte lanes and then keeps
// only the bits named by its keep-mask. Assumes one-hot write enables.
module audbank_ctl_regs
    import audbank_pkg::*;
#(
    parameter int N = NUM_CTL
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N-1:0]       we_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [REG_W-1:0]   lane_mask_i,
    output logic [N*REG_W-1:0] regs_o
);

    for (genvar k = 0; k < N; k++) begin : g_reg
        localparam logic [REG_W-1:0] KEEP = ctl_mask(k);
        logic [REG_W-1:0] q;
        logic [REG_W-1:0] merged;

        // Lane merge followed by the per-register keep-mask.
        always_comb merged = ((q & ~lane_mask_i) | (wdata_i & lane_mask_i)) & KEEP;

        // Register update on a selected write.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)      q <= '0;
            else if (we_i[k]) q <= merged;
        end

        assign regs_o[k*REG_W +: REG_W] = q;
    end

endmodule

// File: rtl/audbank_wave.sv
// Module: audbank_wave
// Waveform sample memory of 32-bit words written by halfword; the half not
// addressed and the byte lanes not enabled keep their stored value.
module audbank_wave
    import audbank_pkg::*;
#(
    parameter int WORDS = WAVE_WORDS
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     we_i,
    input  logic [$clog2(WORDS)-1:0] word_i,
    input  logic                     half_i,
    input  logic [REG_W-1:0]         wdata_i,
    input  logic [REG_W-1:0]         lane_mask_i,
    output logic [WORDS*WORD_W-1:0]  wave_o
);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic [WORD_W-1:0] q;
        logic [REG_W-1:0]  lo_n, hi_n;

        // Merged halves for a write into this word.
        always_comb begin
            lo_n = (q[REG_W-1:0] & ~lane_mask_i) | (wdata_i & lane_mask_i);
            hi_n = (q[WORD_W-1:REG_W] & ~lane_mask_i) | (wdata_i & lane_mask_i);
        end

        // Update one half of the word; the other half is retained.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                q <= '0;
            end else if (we_i && word_i == w) begin
                if (half_i) q[WORD_W-1:REG_W] <= hi_n;
                else        q[REG_W-1:0]      <= lo_n;
            end
        end

        assign wave_o[w*WORD_W +: WORD_W] = q;
    end

endmodule

// File: rtl/audbank_top.sv
// Module: audbank_top
// Audio control register bank: masked channel registers behind a master
// enable gate, master and bias registers, and an ungated waveform memory.
// Reads are registered one cycle; unmapped addresses read 0.
module audbank_top
    import audbank_pkg::*;
(
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic [HW_ADDR_W-1:0]         hw_addr_i,
    input  logic                         wr_en_i,
    input  logic [1:0]                   be_i,
    input  logic [REG_W-1:0]             wr_data_i,
    input  logic                         rd_en_i,
    output logic [REG_W-1:0]             rd_data_o,
    input  logic [STATUS_W-1:0]          chan_active_i,
    output logic [NUM_CTL*REG_W-1:0]     chan_regs_o,
    output logic                         master_en_o,
    output logic [REG_W-1:0]             bias_o,
    output logic [WAVE_WORDS*WORD_W-1:0] wave_o
);

    slot_t              slot;
    logic               blocked;
    logic [REG_W-1:0]   lane_mask;
    logic [NUM_CTL-1:0] ctl_we;
    logic               master_we, bias_we, wave_we;
    logic               en_q;
    logic [REG_W-1:0]   bias_q;
    logic [REG_W-1:0]   rd_val;
    logic [REG_W-1:0]   master_view;

    audbank_decode u_dec (
        .hw_addr_i   (hw_addr_i),
        .wr_en_i     (wr_en_i),
        .be_i        (be_i),
        .master_en_i (en_q),
        .slot_o      (slot),
        .blocked_o   (blocked),
        .lane_mask_o (lane_mask),
        .ctl_we_o    (ctl_we),
        .master_we_o (master_we),
        .bias_we_o   (bias_we),
        .wave_we_o   (wave_we)
    );

    audbank_ctl_regs #(.N(NUM_CTL)) u_ctl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (ctl_we),
        .wdata_i     (wr_data_i),
        .lane_mask_i (lane_mask),
        .regs_o      (chan_regs_o)
    );

    audbank_wave #(.WORDS(WAVE_WORDS)) u_wave (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (wave_we),
        .word_i      (slot.word),
        .half_i      (slot.half),
        .wdata_i     (wr_data_i),
        .lane_mask_i (lane_mask),
        .wave_o      (wave_o)
    );

    // Master enable: only the enable bit is writable, via the low lane.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        en_q <= 1'b0;
        else if (master_we) en_q <= wr_data_i[EN_BIT];
    end

    // Bias register: full-width lane-merged storage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      bias_q <= BIAS_RST;
        else if (bias_we) bias_q <= (bias_q & ~lane_mask) | (wr_data_i & lane_mask);
    end

    // Master register as seen on a read: enable bit plus live channel status.
    always_comb begin
        master_view = '0;
        master_view[EN_BIT] = en_q;
        master_view[STATUS_W-1:0] = chan_active_i;
    end

    // Select the read value for the addressed slot, zero when gated or unmapped.
    always_comb begin
        case (slot.kind)
            KIND_CTL:    rd_val = blocked ? '0 : chan_regs_o[slot.ctl_idx*REG_W +: REG_W];
            KIND_MASTER: rd_val = master_view;
            KIND_BIAS:   rd_val = bias_q;
            KIND_WAVE:   rd_val = wave_o[REG_W*{slot.word, slot.half} +: REG_W];
            default:     rd_val = '0;
        endcase
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_val;
    end

    assign master_en_o = en_q;
    assign bias_o      = bias_q;

endmodule

// File: rtl/audbank_chk.sv
// Module: audbank_chk
// Port-level assertions for audbank_top, attached with a bind below.
module audbank_chk
    import audbank_pkg::*;
(
    input logic                         clk_i,
    input logic                         rst_ni,
    input logic [HW_ADDR_W-1:0]         hw_addr_i,
    input logic                         wr_en_i,
    input logic [1:0]                   be_i,
    input logic [REG_W-1:0]             wr_data_i,
    input logic                         rd_en_i,
    input logic [REG_W-1:0]             rd_data_o,
    input logic [STATUS_W-1:0]          chan_active_i,
    input logic [NUM_CTL*REG_W-1:0]     chan_regs_o,
    input logic                         master_en_o,
    input logic [REG_W-1:0]             bias_o,
    input logic [WAVE_WORDS*WORD_W-1:0] wave_o
);

    // R1: reset leaves bias at its default and the enable clear.
    a_r1_reset_values: assert property (@(posedge clk_i)
        !rst_ni |=> (bias_o == BIAS_RST) && !master_en_o && (rd_data_o == '0));

    // R5: gated writes leave the channel registers untouched.
    a_r5_gated_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !master_en_o && hw_addr_i <= GATE_LAST) |=> $stable(chan_regs_o));

    // R6: gated reads return zero.
    a_r6_gated_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !master_en_o && hw_addr_i <= GATE_LAST) |=> rd_data_o == '0);

    // R4: master read shows the enable and the channel status only.
    a_r4_master_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && hw_addr_i == 6'h12) |=>
        rd_data_o == {8'h00, $past(master_en_o), 3'b000, $past(chan_active_i)});

    // R7: full-lane write to word 0 low half appears on the wave output.
    a_r7_wave_low_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && hw_addr_i == 6'h18 && be_i == 2'b11) |=> wave_o[15:0] == $past(wr_data_i));

    // R9: addresses past the map read zero.
    a_r9_upper_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && hw_addr_i >= 6'h20) |=> rd_data_o == '0);

    // R10: read data holds while no read is issued.
    a_r10_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

bind audbank_top audbank_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hw_addr_i     (hw_addr_i),
    .wr_en_i       (wr_en_i),
    .be_i          (be_i),
    .wr_data_i     (wr_data_i),
    .rd_en_i       (rd_en_i),
    .rd_data_o     (rd_data_o),
    .chan_active_i (chan_active_i),
    .chan_regs_o   (chan_regs_o),
    .master_en_o   (master_en_o),
    .bias_o        (bias_o),
    .wave_o        (wave_o)
);

// File: tb/sim_audbank_top.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected read data, plus direct port checks.
module sim_audbank_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [5:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   be = '0;
    logic [15:0]  wdata = '0;
    logic         rd_en = 1'b0;
    logic [15:0]  rdata;
    logic [3:0]   act = '0;
    logic [191:0] regs;
    logic         men;
    logic [15:0]  bias;
    logic [127:0] wave;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];
    logic  pend = 1'b0;

    always #10 clk = ~clk;

    audbank_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .hw_addr_i(addr), .wr_en_i(wr_en),
        .be_i(be), .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rdata),
        .chan_active_i(act), .chan_regs_o(regs), .master_en_o(men),
        .bias_o(bias), .wave_o(wave)
    );

    function automatic logic [15:0] slot(input int k);
        return regs[16*k +: 16];
    endfunction

    task automatic check(input string tag, input logic [127:0] act_v, input logic [127:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] b);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        wr_en = 1'b0; be = 2'b00;
    endtask

    task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        sb.push_back('{exp: e, tag: tag});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Monitor: mark a read captured on this edge.
    always @(posedge clk) pend <= rd_en && rst_n;

    // Monitor: compare captured read data with the oldest expectation.
    always @(negedge clk) begin
        if (pend) begin
            item_t it;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected read actual=%0h expected=none", rdata);
            end else begin
                it = sb.pop_front();
                if (rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s read actual=%0h expected=%0h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [191:0] snap_regs;
        logic [127:0] snap_wave;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 regs", regs, '0);
        check("R1 master_en", men, 1'b0);
        check("R1 bias", bias, 16'h0200);
        check("R1 wave", wave, '0);
        check("R1 rd_data", rdata, 16'h0);
        rd(6'h14, 16'h0200, "R1 bias read");

        // Master off: gated write dropped, gated read zero, 0x11 still open.
        wr(6'h00, 16'hFFFF, 2'b11);
        check("R5 sweep write while off", slot(0), 16'h0);
        rd(6'h00, 16'h0, "R6 sweep read while off");
        wr(6'h11, 16'hFFFF, 2'b11);
        check("R2 dma-mix mask", slot(11), 16'h770F);
        rd(6'h11, 16'h770F, "R6 dma-mix readable while off");

        // Waveform memory while master off.
        wr(6'h18, 16'h1234, 2'b11);
        wr(6'h19, 16'hABCD, 2'b11);
        check("R8 wave word0 while off", wave[31:0], 32'hABCD1234);
        rd(6'h18, 16'h1234, "R7 wave low read");
        rd(6'h19, 16'hABCD, "R7 wave high read");
        wr(6'h18, 16'h5600, 2'b10);
        check("R3 wave high-lane merge", wave[31:0], 32'hABCD5634);
        wr(6'h1F, 16'hBEEF, 2'b11);
        check("R7 wave word3 high", wave[127:96], 32'hBEEF0000);

        // Enable the master; low status bits come from the channels.
        act = 4'hA;
        wr(6'h12, 16'h00FF, 2'b01);
        check("R4 master enable set", men, 1'b1);
        rd(6'h12, 16'h008A, "R4 master read");

        // Keep-masks with all-ones writes.
        begin
            logic [5:0]  adr [11] = '{6'h00, 6'h02, 6'h06, 6'h08, 6'h09, 6'h0A,
                                      6'h0C, 6'h0E, 6'h10, 6'h01, 6'h04};
            int          sl  [11] = '{0, 2, 4, 5, 6, 7, 8, 9, 10, 1, 3};
            logic [15:0] ex  [11] = '{16'h007F, 16'h47FF, 16'h47FF, 16'h00E0, 16'hE03F,
                                      16'h47FF, 16'hFF3F, 16'h40FF, 16'hFF77, 16'hFFFF, 16'hFFFF};
            for (int i = 0; i < 11; i++) begin
                wr(adr[i], 16'hFFFF, 2'b11);
                check($sformatf("R2 mask slot %0d", sl[i]), slot(sl[i]), ex[i]);
                rd(adr[i], ex[i], $sformatf("R2 mask read slot %0d", sl[i]));
            end
        end

        // Byte-lane merges over non-zero contents.
        wr(6'h01, 16'h1200, 2'b10);
        check("R3 high lane on ch1 env", slot(1), 16'h12FF);
        wr(6'h02, 16'h0000, 2'b10);
        check("R3 high lane masked ch1 freq", slot(2), 16'h00FF);
        wr(6'h09, 16'h0011, 2'b01);
        check("R3 low lane masked ch3 len", slot(6), 16'hE011);

        // Disable the master; status bits still follow the channels.
        act = 4'h5;
        wr(6'h12, 16'h0000, 2'b01);
        check("R4 master enable cleared", men, 1'b0);
        rd(6'h12, 16'h0005, "R4 master read status");
        act = 4'h0;
        wr(6'h12, 16'hFFFF, 2'b10);
        check("R4 high-lane write ignored", men, 1'b0);

        rd(6'h00, 16'h0, "R6 sweep read zero while off");
        rd(6'h10, 16'h0, "R6 lr-mix read zero while off");
        check("R6 sweep retained", slot(0), 16'h007F);
        wr(6'h00, 16'h0000, 2'b11);
        check("R5 sweep write dropped", slot(0), 16'h007F);
        wr(6'h10, 16'h0000, 2'b11);
        check("R5 lr-mix write dropped", slot(10), 16'hFF77);
        rd(6'h11, 16'h770F, "R6 dma-mix read while off");
        wr(6'h14, 16'h1234, 2'b11);
        check("R6 bias written while off", bias, 16'h1234);
        rd(6'h14, 16'h1234, "R6 bias read while off");

        wr(6'h1A, 16'hCAFE, 2'b11);
        check("R8 wave word1 write while off", wave[63:32], 32'h0000CAFE);
        rd(6'h1A, 16'hCAFE, "R8 wave read while off");

        // Unmapped addresses.
        snap_regs = regs;
        snap_wave = wave;
        wr(6'h03, 16'hFFFF, 2'b11);
        wr(6'h3F, 16'hFFFF, 2'b11);
        wr(6'h13, 16'hFFFF, 2'b11);
        check("R9 regs unchanged", regs, snap_regs);
        check("R9 wave unchanged", wave, snap_wave);
        check("R9 bias unchanged", bias, 16'h1234);
        rd(6'h03, 16'h0, "R9 hole read");
        rd(6'h20, 16'h0, "R9 upper read");
        rd(6'h07, 16'h0, "R9 hole read 0x07");

        // Read data holds between reads.
        rd(6'h19, 16'hABCD, "R10 read");
        repeat (3) @(negedge clk);
        check("R10 hold", rdata, 16'hABCD);

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule